// File: doc/BRIEF.md
# Ethernet MAC Interrupt Controller

This block gathers the interrupt causes of a 10/100 Ethernet MAC into one latched status byte. It filters that byte through a host-programmable mask and drives a single registered interrupt line. The host reaches the block over a 16-bit bus with two byte enables. One word address carries a write-only acknowledge byte in its low half and the mask in its high half. Further addresses hold the control enables, the receive-discard counter and an exception detail word.

Five ordinary event causes are latched from pulses and cleared by acknowledge. Two further status bits behave differently. The exception summary is the enabled OR of three protocol-handler conditions: a link-state change, a statistics rollover and a fatal transmit error. Each condition has its own way of being cleared, and none of them clears on acknowledge. The discard bit comes from a saturating 8-bit counter of receive-discard pulses.

Top module: `eth_irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[n]` (n = 0..4) sets status bit n, which holds until a write to address 0 with `be_i[0]`=1 and `wdata_i[n]`=1. If that write and a new pulse arrive in the same cycle, the bit stays set.
- R2: Address 0 with `be_i[1]`=1 writes the mask from `wdata_i[15:8]`, either as part of a full word write or alone. `be_i[0]` alone leaves the mask unchanged. A read of address 0 returns the mask in `rdata_o[15:8]` and the status in `rdata_o[7:0]`.
- R3: `irq_o` equals the OR over all bits of (status AND mask), taken one clock after the status or mask value. It is 0 after reset.
- R4: Each `disc_i` pulse increments an 8-bit counter, readable at address 2 in `rdata_o[7:0]`. The counter saturates at 0xFF. Status bit 6 sets in the cycle the counter becomes 0xFF.
- R5: Status bit 6 stays set until an acknowledge write with bit 6 = 1. Once cleared, it does not set again while the counter is held at 0xFF.
- R6: Status bit 5 is the OR of the link, rollover and transmit-fault latches, each gated by its enable in control register bits 0, 1 and 2 (address 1, `be_i[0]`). Writing acknowledge bit 5 has no effect on it.
- R7: Any change of `link_i` sets the link latch. The latch clears only on a control write with bit 0 = 0. Address 3 bit 8 reads the latch and bit 0 reads the live `link_i`.
- R8: A `roll_i` pulse sets the rollover latch (address 3 bit 1). A read of address 2 clears it. A pulse in the same cycle as that read keeps it set.
- R9: A `tx_err_i` pulse sets the transmit-fault latch and clears the transmit-enable flag (address 3 bit 2, control bit 3). It also clears the transmit-success flag (address 3 bit 3, set by `tx_ok_i`). It records reason `tx_reason_i` (0 SQE error, 1 lost carrier, 2 late collision, 3 sixteen collisions) one-hot in address 3 bits 7:4, as bit 4+reason. A control write with bit 3 = 1 clears the fault and sets transmit-enable.
- R10: Status bit 7 and mask bit 7 always read 0. A mask write with bit 15 = 1 leaves mask bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Host word address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe (side effect on address 2) |
| be_i | input | 2 | Byte enables, bit 0 low byte |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| evt_i | input | 5 | Ordinary event pulses |
| disc_i | input | 1 | Receive-discard pulse |
| link_i | input | 1 | Link state level |
| roll_i | input | 1 | Statistics rollover pulse |
| tx_err_i | input | 1 | Fatal transmit error pulse |
| tx_reason_i | input | 2 | Reason code qualifying `tx_err_i` |
| tx_ok_i | input | 1 | Transmit success pulse |
| irq_o | output | 1 | Host interrupt, registered |

## Verification
A status latch in the wrong state reaches `irq_o` exactly one clock later whenever its mask bit is set. The bench therefore compares the interrupt line against an independent model on every cycle, under masks that both expose and hide each bit. A latch hidden by its mask or enable shows only on a host read. For that reason every phase of the bench ends with reads of the status, counter and exception words. A clear rule applied to the wrong bit, such as acknowledge touching the summary or a read failing to drop the rollover latch, then shows in the very next read.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = DATA_W / 2;
  localparam int ADDR_W  = 2;
  localparam int NUM_EVT = 5;
  localparam int CNT_W   = 8;
  localparam int RSN_W   = 2;
  localparam int NUM_RSN = 1 << RSN_W;

  localparam logic [ADDR_W-1:0] A_IRQ  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_EXC  = 2'd3;

  localparam int ST_EXC  = NUM_EVT;
  localparam int ST_DISC = NUM_EVT + 1;
  localparam int ST_RSVD = BYTE_W - 1;

  typedef struct packed {
    logic txerr_en;
    logic roll_en;
    logic link_en;
  } exc_en_t;
endpackage

// File: rtl/eic_host_regs.sv
`timescale 1ns/1ps
module eic_host_regs
  import eic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] mask_o,
  output logic [BYTE_W-1:0] ack_o,
  output exc_en_t           en_o,
  output logic              ctrl_wr_o,
  output logic              cnt_rd_o
);
  localparam logic [BYTE_W-1:0] RSVD_M = ~(BYTE_W'(1) << ST_RSVD);

  logic wr_irq;
  assign wr_irq    = wr_i && (addr_i == A_IRQ);
  assign ctrl_wr_o = wr_i && (addr_i == A_CTRL) && be_i[0];
  assign cnt_rd_o  = rd_i && (addr_i == A_CNT);
  assign ack_o     = (wr_irq && be_i[0]) ? (wdata_i[BYTE_W-1:0] & RSVD_M) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      en_o   <= '0;
    end else begin
      if (wr_irq && be_i[1]) mask_o <= wdata_i[DATA_W-1:BYTE_W] & RSVD_M;
      if (ctrl_wr_o)         en_o   <= exc_en_t'(wdata_i[2:0]);
    end
  end
endmodule

// File: rtl/eic_exc_unit.sv
`timescale 1ns/1ps
module eic_exc_unit
  import eic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  exc_en_t            en_i,
  input  logic               ctrl_wr_i,
  input  logic               link_en_wd_i,
  input  logic               txen_wd_i,
  input  logic               cnt_rd_i,
  input  logic               link_i,
  input  logic               roll_i,
  input  logic               tx_err_i,
  input  logic [RSN_W-1:0]   tx_reason_i,
  input  logic               tx_ok_i,
  output logic               exc_o,
  output logic               link_lat_o,
  output logic               roll_lat_o,
  output logic               txen_o,
  output logic               tx_suc_o,
  output logic [NUM_RSN-1:0] reason_o
);
  logic link_q, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q     <= 1'b0;
      link_lat_o <= 1'b0;
      roll_lat_o <= 1'b0;
      fault_q    <= 1'b0;
      txen_o     <= 1'b0;
      tx_suc_o   <= 1'b0;
      reason_o   <= '0;
    end else begin
      link_q <= link_i;
      // each latch: set has priority over its clear rule
      if (link_i != link_q)                link_lat_o <= 1'b1;
      else if (ctrl_wr_i && !link_en_wd_i) link_lat_o <= 1'b0;
      if (roll_i)        roll_lat_o <= 1'b1;
      else if (cnt_rd_i) roll_lat_o <= 1'b0;
      if (tx_err_i) begin
        fault_q  <= 1'b1;
        txen_o   <= 1'b0;
        tx_suc_o <= 1'b0;
        reason_o <= NUM_RSN'(1) << tx_reason_i;
      end else begin
        if (ctrl_wr_i) begin
          txen_o <= txen_wd_i;
          if (txen_wd_i) fault_q <= 1'b0;
        end
        if (tx_ok_i) tx_suc_o <= 1'b1;
      end
    end
  end

  assign exc_o = (link_lat_o & en_i.link_en) | (roll_lat_o & en_i.roll_en) |
                 (fault_q & en_i.txerr_en);
endmodule

// File: rtl/eic_disc_cnt.sv
`timescale 1ns/1ps
module eic_disc_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         disc_i,
  input  logic         ack_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  localparam logic [W-1:0] TOP = '1;
  logic hit;
  assign hit = disc_i && (cnt_o == TOP - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      full_o <= 1'b0;
    end else begin
      if (disc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
      if (hit)        full_o <= 1'b1;
      else if (ack_i) full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_irq_ctrl.sv
`timescale 1ns/1ps
module eth_irq_ctrl
  import eic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [1:0]         be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               disc_i,
  input  logic               link_i,
  input  logic               roll_i,
  input  logic               tx_err_i,
  input  logic [RSN_W-1:0]   tx_reason_i,
  input  logic               tx_ok_i,
  output logic               irq_o
);
  logic [BYTE_W-1:0]  mask, ack, status;
  exc_en_t            en;
  logic               ctrl_wr, cnt_rd, exc, link_lat, roll_lat, txen, tx_suc, disc_full;
  logic [NUM_RSN-1:0] reason;
  logic [CNT_W-1:0]   disc_cnt;
  logic [NUM_EVT-1:0] evt_lat;

  eic_host_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .be_i, .wdata_i,
    .mask_o(mask), .ack_o(ack), .en_o(en), .ctrl_wr_o(ctrl_wr), .cnt_rd_o(cnt_rd)
  );

  eic_exc_unit u_exc (
    .clk_i, .rst_ni, .en_i(en), .ctrl_wr_i(ctrl_wr),
    .link_en_wd_i(wdata_i[0]), .txen_wd_i(wdata_i[3]), .cnt_rd_i(cnt_rd),
    .link_i, .roll_i, .tx_err_i, .tx_reason_i, .tx_ok_i,
    .exc_o(exc), .link_lat_o(link_lat), .roll_lat_o(roll_lat),
    .txen_o(txen), .tx_suc_o(tx_suc), .reason_o(reason)
  );

  eic_disc_cnt #(.W(CNT_W)) u_disc (
    .clk_i, .rst_ni, .disc_i, .ack_i(ack[ST_DISC]), .cnt_o(disc_cnt), .full_o(disc_full)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        evt_lat[i] <= 1'b0;
      else if (evt_i[i])  evt_lat[i] <= 1'b1;
      else if (ack[i])    evt_lat[i] <= 1'b0;
    end
  end

  assign status = {1'b0, disc_full, exc, evt_lat};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status & mask);
  end

  always_comb begin
    unique case (addr_i)
      A_IRQ:   rdata_o = {mask, status};
      A_CTRL:  rdata_o = DATA_W'({txen, en});
      A_CNT:   rdata_o = DATA_W'(disc_cnt);
      default: rdata_o = DATA_W'({link_lat, reason, tx_suc, txen, roll_lat, link_i});
    endcase
  end
endmodule

// File: rtl/eic_checker.sv
`timescale 1ns/1ps
module eic_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] status_i,
  input logic [7:0] mask_i,
  input logic [7:0] ack_i,
  input logic [7:0] cnt_i,
  input logic       irq_i,
  input logic       disc_lat_i,
  input logic       link_lat_i,
  input logic       ctrl_wr_i,
  input logic       link_en_wd_i,
  input logic       tx_err_i,
  input logic       txen_i,
  input logic       tx_suc_i
);
  assert_irq_lag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == $past(|(status_i & mask_i))));
  assert_rsvd_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_i[7] && !status_i[7]);
  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == 8'hFF) |=> (cnt_i == 8'hFF));
  assert_disc_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disc_lat_i && !ack_i[6]) |=> disc_lat_i);
  assert_link_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_lat_i && !(ctrl_wr_i && !link_en_wd_i)) |=> link_lat_i);
  assert_txerr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_i |=> (!txen_i && !tx_suc_i));
endmodule

bind eth_irq_ctrl eic_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status), .mask_i(mask), .ack_i(ack),
  .cnt_i(disc_cnt), .irq_i(irq_o), .disc_lat_i(disc_full), .link_lat_i(link_lat),
  .ctrl_wr_i(ctrl_wr), .link_en_wd_i(wdata_i[0]), .tx_err_i(tx_err_i),
  .txen_i(txen), .tx_suc_i(tx_suc)
);

// File: tb/eth_irq_ctrl_test.sv
`timescale 1ns/1ps
module eth_irq_ctrl_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = '0, be_i = '0, tx_reason_i = '0;
  logic wr_i = 0, rd_i = 0, disc_i = 0, link_i = 0, roll_i = 0, tx_err_i = 0, tx_ok_i = 0;
  logic [15:0] wdata_i = '0;
  logic [4:0]  evt_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  eth_irq_ctrl uut (.*);

  // behavioural reference state
  logic [7:0] m_mask = 0, m_cnt = 0;
  logic [4:0] m_evt = 0;
  logic [3:0] m_rsn = 0;
  logic [2:0] m_en = 0;
  logic m_irq = 0, m_disc = 0, m_link_prev = 0, m_link = 0, m_roll = 0;
  logic m_fault = 0, m_txen = 0, m_suc = 0;

  function automatic logic [7:0] m_status();
    logic exc;
    exc = (m_link & m_en[0]) | (m_roll & m_en[1]) | (m_fault & m_en[2]);
    return {1'b0, m_disc, exc, m_evt};
  endfunction

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_mask, m_status()};
      2'd1: return {12'd0, m_txen, m_en};
      2'd2: return {8'd0, m_cnt};
      default: return {7'd0, m_link, m_rsn, m_suc, m_txen, m_roll, link_i};
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = 0; m_cnt = 0; m_evt = 0; m_rsn = 0; m_en = 0; m_irq = 0; m_disc = 0;
      m_link_prev = 0; m_link = 0; m_roll = 0; m_fault = 0; m_txen = 0; m_suc = 0;
    end else begin
      logic [7:0] ack;
      logic cw;
      m_irq = |(m_status() & m_mask);
      ack = (wr_i && addr_i == 0 && be_i[0]) ? wdata_i[7:0] : 8'd0;
      cw  = wr_i && addr_i == 1 && be_i[0];
      m_evt = (m_evt & ~ack[4:0]) | evt_i;
      if (wr_i && addr_i == 0 && be_i[1]) m_mask = wdata_i[15:8] & 8'h7F;
      if (cw) m_en = wdata_i[2:0];
      if (disc_i && m_cnt != 8'hFF) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == 8'hFF) m_disc = 1;
        else if (ack[6]) m_disc = 0;
      end else if (ack[6]) m_disc = 0;
      if (link_i != m_link_prev) m_link = 1;
      else if (cw && !wdata_i[0]) m_link = 0;
      m_link_prev = link_i;
      if (roll_i) m_roll = 1;
      else if (rd_i && addr_i == 2) m_roll = 0;
      if (tx_err_i) begin
        m_fault = 1; m_txen = 0; m_suc = 0; m_rsn = 4'd1 << tx_reason_i;
      end else begin
        if (cw) begin m_txen = wdata_i[3]; if (wdata_i[3]) m_fault = 0; end
        if (tx_ok_i) m_suc = 1;
      end
    end
  end

  // R3: interrupt line against the model on every clock
  always @(negedge clk_i) if (rst_ni) begin
    checks++;
    if (irq_o !== m_irq) begin
      fails++;
      $display("FAIL R3 irq_o actual=%0b expected=%0b t=%0t", irq_o, m_irq, $time);
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag);
    @(negedge clk_i); addr_i = a; rd_i = 1; #2;
    chk(rdata_o, m_read(a), tag);
    @(negedge clk_i); rd_i = 0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i); addr_i = a; be_i = be; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0; be_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_ni = 1;
    // reset state
    @(negedge clk_i); #2;
    chk({15'd0, irq_o}, 16'd0, "R3 reset irq");
    chk(rdata_o, 16'd0, "R2 reset status/mask");
    // R2 / R10: high byte only, bit 15 forced low
    bus_wr(0, 2'b10, 16'hFF00);
    rd_chk(0, "R2 R10 mask high byte");
    @(negedge clk_i); #2; chk(rdata_o, 16'h7F00, "R10 mask bit7 low");
    bus_wr(0, 2'b01, 16'h0000);
    rd_chk(0, "R2 low byte leaves mask");
    // R1: event latch and acknowledge
    @(negedge clk_i); evt_i = 5'b00001; @(negedge clk_i); evt_i = 0;
    idle(2);
    rd_chk(0, "R1 event set");
    bus_wr(0, 2'b01, 16'h0001);
    rd_chk(0, "R1 event acked");
    // R1: same-cycle set and ack, set wins
    @(negedge clk_i); evt_i = 5'b00100; addr_i = 0; be_i = 2'b01; wdata_i = 16'h0004; wr_i = 1;
    @(negedge clk_i); evt_i = 0; wr_i = 0; be_i = 0;
    rd_chk(0, "R1 set beats ack");
    // R3: mask down, then word write with ack
    bus_wr(0, 2'b11, 16'h0000);
    idle(2);
    rd_chk(0, "R3 masked off");
    bus_wr(0, 2'b11, 16'h7F04);
    idle(2);
    rd_chk(0, "R2 R3 word write");
    // R4 / R5: discard counter
    for (int i = 0; i < 254; i++) begin
      @(negedge clk_i); disc_i = 1;
    end
    @(negedge clk_i); disc_i = 0;
    rd_chk(2, "R4 count 254");
    rd_chk(0, "R4 not yet full");
    @(negedge clk_i); disc_i = 1; @(negedge clk_i); disc_i = 0;
    @(negedge clk_i); addr_i = 2; #2; chk(rdata_o, 16'h00FF, "R4 count at FF");
    addr_i = 0; #1; chk({15'd0, rdata_o[6]}, 16'd1, "R4 discard status set");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); disc_i = 1;
    end
    @(negedge clk_i); disc_i = 0;
    rd_chk(2, "R4 saturates");
    bus_wr(0, 2'b01, 16'h0020);
    rd_chk(0, "R5 ack other bit keeps discard");
    bus_wr(0, 2'b01, 16'h0040);
    @(negedge clk_i); disc_i = 1; @(negedge clk_i); disc_i = 0;
    rd_chk(0, "R5 cleared and not re-set");
    // R6 / R7: link exception
    bus_wr(1, 2'b01, 16'h0001);
    @(negedge clk_i); link_i = 1;
    idle(2);
    rd_chk(3, "R7 link latch");
    rd_chk(0, "R6 summary from link");
    bus_wr(0, 2'b01, 16'h0020);
    rd_chk(0, "R6 ack does not clear summary");
    bus_wr(1, 2'b01, 16'h0000);
    rd_chk(3, "R7 cleared by enable low");
    rd_chk(0, "R6 summary gone");
    // R8: rollover cleared by counter read, set wins
    bus_wr(1, 2'b01, 16'h0002);
    @(negedge clk_i); roll_i = 1; @(negedge clk_i); roll_i = 0;
    rd_chk(0, "R8 rollover summary");
    @(negedge clk_i); roll_i = 1; addr_i = 2; rd_i = 1;
    @(negedge clk_i); roll_i = 0; rd_i = 0;
    rd_chk(3, "R8 set beats read");
    rd_chk(2, "R8 read clears");
    rd_chk(3, "R8 cleared");
    // R9: fatal transmit error
    bus_wr(1, 2'b01, 16'h000C);
    @(negedge clk_i); tx_ok_i = 1; @(negedge clk_i); tx_ok_i = 0;
    rd_chk(3, "R9 tx ok");
    @(negedge clk_i); tx_err_i = 1; tx_reason_i = 2; @(negedge clk_i); tx_err_i = 0;
    @(negedge clk_i); addr_i = 3; #2;
    chk(rdata_o & 16'h00FC, 16'h0040, "R9 late collision, txen and ok low");
    rd_chk(0, "R9 summary");
    @(negedge clk_i); tx_err_i = 1; tx_reason_i = 3; @(negedge clk_i); tx_err_i = 0;
    rd_chk(3, "R9 sixteen collisions");
    bus_wr(1, 2'b01, 16'h000C);
    rd_chk(1, "R9 txen restored");
    rd_chk(0, "R9 fault cleared");
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule